// File: doc/BRIEF.md
# Rate-Selected Demodulation Path Router

This block sits between an OFDM equalizer and a bank of demapping chains. It accepts one equalized data symbol at a time on a valid/ready input and hands it to exactly one of five outputs. Output 0 feeds the header chain, which demaps with BPSK. Outputs 1 to 4 feed the data chains, each serving a pair of data rates.

At the start of a frame the router is in its header phase, and every symbol goes to output 0. When the parser upstream signals that the header is done, the router captures the 4-bit rate code presented with that pulse. Until the end of the frame it steers symbols to the data output that serves that rate.

At end of frame the router returns to the header phase. On the following cycle it issues a one-cycle reset strobe to output 0 and to the one data chain that was used in the frame. The other chains see no reset. A rate code outside the known set blocks the stream and raises an error flag. The flag stays set until the frame ends.

Top module: `demod_path_router`

## Requirements
- R1: While in the header phase, `out_valid[0]` follows `in_valid`, `in_ready` follows `out_ready[0]`, and `out_valid[4:1]` stay 0.
- R2: On `hdr_done` in the header phase, `rate_code` is captured and the data phase begins on the next cycle. Codes 0 and 1 (6 and 9 Mbit/s) route to output 1, codes 2 and 3 (12, 18) to output 2, codes 4 and 5 (24, 36) to output 3, and codes 6 and 7 (48, 54) to output 4.
- R3: In the data phase, only the selected output's valid follows `in_valid`, and `in_ready` equals that output's ready. `out_data` always equals `in_data`.
- R4: Once the data phase has begun, changes on `rate_code` and further `hdr_done` pulses do not change the selected output until end of frame.
- R5: `frame_end` in the data phase with a valid code produces, on the next cycle only, `path_rst` with bit 0 and the selected output's bit set and all other bits clear.
- R6: `frame_end` in the header phase produces `path_rst` = 5'b00001 for one cycle, and the block stays in the header phase.
- R7: A captured code of 8 to 15 sets `rate_err` on the next cycle. While it is set, all `out_valid` bits are 0 and `in_ready` is 0.
- R8: `frame_end` clears `rate_err` and returns routing to output 0 on the next cycle. If the code was invalid, `path_rst` is 5'b00001.
- R9: After reset the block is in the header phase with `path_rst` = 0 and `rate_err` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input symbol valid |
| in_data | input | 32 | Equalized symbol |
| in_ready | output | 1 | Input accepted when high with in_valid |
| out_valid | output | 5 | Per-output valid, bit 0 is the header chain |
| out_ready | input | 5 | Per-output ready |
| out_data | output | 32 | Symbol shared by all outputs |
| rate_code | input | 4 | Rate code, sampled with hdr_done |
| hdr_done | input | 1 | Header parsed pulse |
| frame_end | input | 1 | End of frame pulse |
| path_rst | output | 5 | One-cycle per-chain reset strobes |
| rate_err | output | 1 | Sticky unknown-rate flag |

## Verification
The case that is hardest to reach from the ports is a change on the rate input while a frame is in its data phase. Routing must ignore it, and the end-of-frame strobe must still name the chain picked at capture time. The bench reaches it by capturing one code, changing `rate_code` and pulsing `hdr_done` again mid-frame, and then checking both the routing and the strobe pattern. It reaches the blocked state by capturing an invalid code and then offering traffic with every output ready.

// File: rtl/demod_router_pkg.sv
package demod_router_pkg;
  typedef enum logic {ST_HDR = 1'b0, ST_DATA = 1'b1} frame_st_t;
endpackage

// File: rtl/rate_decoder.sv
module rate_decoder #(
  parameter int CODE_W  = 4,
  parameter int N_DATA  = 4,
  localparam int NPATH  = N_DATA + 1
) (
  input  logic [CODE_W-1:0] code,
  output logic [NPATH-1:0]  hot,
  output logic              ok
);
  // Two consecutive codes share one data path; path index = code/2 + 1.
  assign ok = (32'(code) < 2 * N_DATA);
  assign hot[0] = 1'b0;
  for (genvar p = 1; p < NPATH; p++) begin : g_path
    assign hot[p] = ok && ((32'(code) >> 1) == (p - 1));
  end
endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import demod_router_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int N_DATA = 4,
  localparam int NPATH = N_DATA + 1
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              hdr_done,
  input  logic              frame_end,
  output logic [NPATH-1:0]  route_sel,
  output logic [NPATH-1:0]  path_rst,
  output logic              rate_err
);
  frame_st_t         st_q, st_d;
  logic [CODE_W-1:0] rate_q;
  logic              load_en;
  logic              err_q, err_d;
  logic [NPATH-1:0]  rst_q, rst_d;
  logic [NPATH-1:0]  hot_in, hot_q;
  logic              ok_in, ok_q;

  rate_decoder #(.CODE_W(CODE_W), .N_DATA(N_DATA)) u_dec_in (
    .code(rate_code), .hot(hot_in), .ok(ok_in));
  rate_decoder #(.CODE_W(CODE_W), .N_DATA(N_DATA)) u_dec_q (
    .code(rate_q), .hot(hot_q), .ok(ok_q));

  always_comb begin
    st_d    = st_q;
    err_d   = err_q;
    rst_d   = '0;
    load_en = 1'b0;
    if (frame_end) begin
      st_d     = ST_HDR;
      err_d    = 1'b0;
      rst_d[0] = 1'b1;
      if (st_q == ST_DATA) rst_d = rst_d | hot_q;
    end else if (hdr_done && st_q == ST_HDR) begin
      st_d    = ST_DATA;
      load_en = 1'b1;
      err_d   = !ok_in;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q  <= ST_HDR;
      err_q <= 1'b0;
      rst_q <= '0;
    end else begin
      st_q  <= st_d;
      err_q <= err_d;
      rst_q <= rst_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      rate_q <= '0;
    else if (load_en) rate_q <= rate_code;
  end

  assign route_sel = (st_q == ST_HDR) ? NPATH'(1) : hot_q;
  assign path_rst  = rst_q;
  assign rate_err  = err_q;

  p_rate_hold_r4: assert property (@(posedge clk) disable iff (!srst_n)
    (st_q == ST_DATA && $past(st_q == ST_DATA)) |-> $stable(rate_q));
  p_rst_hdr_bit_r5: assert property (@(posedge clk) disable iff (!srst_n)
    frame_end |=> path_rst[0]);
  p_rst_count_r5: assert property (@(posedge clk) disable iff (!srst_n)
    $countones(path_rst) <= 2);
  p_err_clear_r8: assert property (@(posedge clk) disable iff (!srst_n)
    frame_end |=> !rate_err);
endmodule

// File: rtl/stream_steer.sv
module stream_steer #(
  parameter int NPATH  = 5,
  parameter int DATA_W = 32
) (
  input  logic [NPATH-1:0]  route_sel,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic [NPATH-1:0]  out_valid,
  input  logic [NPATH-1:0]  out_ready,
  output logic [DATA_W-1:0] out_data
);
  for (genvar p = 0; p < NPATH; p++) begin : g_out
    assign out_valid[p] = in_valid && route_sel[p];
  end
  assign in_ready = |(route_sel & out_ready);
  assign out_data = in_data;

  always_comb begin
    p_one_valid_r3: assert ($onehot0(out_valid));
    if (in_valid && in_ready)
      p_one_taker_r3: assert ($countones(out_valid & out_ready) == 1);
  end
endmodule

// File: rtl/demod_path_router.sv
module demod_path_router #(
  parameter int DATA_W = 32,
  parameter int CODE_W = 4,
  parameter int N_DATA = 4,
  localparam int NPATH = N_DATA + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic [NPATH-1:0]  out_valid,
  input  logic [NPATH-1:0]  out_ready,
  output logic [DATA_W-1:0] out_data,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              hdr_done,
  input  logic              frame_end,
  output logic [NPATH-1:0]  path_rst,
  output logic              rate_err
);
  logic [1:0]       rst_sync;
  logic             srst_n;
  logic [NPATH-1:0] route_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  frame_ctrl #(.CODE_W(CODE_W), .N_DATA(N_DATA)) u_ctrl (
    .clk(clk), .srst_n(srst_n), .rate_code(rate_code), .hdr_done(hdr_done),
    .frame_end(frame_end), .route_sel(route_sel), .path_rst(path_rst),
    .rate_err(rate_err));

  stream_steer #(.NPATH(NPATH), .DATA_W(DATA_W)) u_steer (
    .route_sel(route_sel), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data));

  p_err_blocks_r7: assert property (@(posedge clk) disable iff (!srst_n)
    rate_err |-> (!in_ready && out_valid == '0));
  p_end_to_hdr_r8: assert property (@(posedge clk) disable iff (!srst_n)
    frame_end |=> (in_valid == out_valid[0]));
endmodule

// File: tb/demod_path_router_test.sv
module demod_path_router_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_data;
  logic        in_ready;
  logic [4:0]  out_valid;
  logic [4:0]  out_ready;
  logic [31:0] out_data;
  logic [3:0]  rate_code;
  logic        hdr_done;
  logic        frame_end;
  logic [4:0]  path_rst;
  logic        rate_err;

  int n_chk = 0;
  int n_bad = 0;

  demod_path_router uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .rate_code(rate_code), .hdr_done(hdr_done),
    .frame_end(frame_end), .path_rst(path_rst), .rate_err(rate_err));

  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic hdr_pulse(input logic [3:0] code);
    rate_code = code; hdr_done = 1'b1; step();
    hdr_done = 1'b0;
  endtask

  task automatic end_pulse();
    frame_end = 1'b1; step();
    frame_end = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 0; in_data = 0; out_ready = 0;
    rate_code = 0; hdr_done = 0; frame_end = 0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    check("R9 path_rst", path_rst, 0);
    check("R9 rate_err", rate_err, 0);
    in_valid = 1; #1;
    check("R9 header routing", out_valid, 5'b00001);
    in_valid = 0;
  endtask

  task automatic t_header();
    in_valid = 1; in_data = 32'hA5A5_0001; out_ready = 5'b11110; #1;
    check("R1 valid to path0", out_valid, 5'b00001);
    check("R1 ready from path0", in_ready, 0);
    out_ready = 5'b00001; #1;
    check("R1 ready path0", in_ready, 1);
    check("R3 data", out_data, 32'hA5A5_0001);
    in_valid = 0; #1;
    check("R1 no valid", out_valid, 0);
  endtask

  task automatic t_rate(input logic [3:0] code, input int path);
    hdr_pulse(code);
    in_valid = 1; in_data = {28'h0, code}; out_ready = 5'b11111 ^ (5'b1 << path); #1;
    check("R2 route", out_valid, 1 << path);
    check("R3 ready low when sel not ready", in_ready, 0);
    out_ready = 5'b1 << path; #1;
    check("R3 ready from sel", in_ready, 1);
    check("R3 data", out_data, {28'h0, code});
    in_valid = 0;
    end_pulse();
    check("R5 strobe", path_rst, 5'b00001 | (5'b1 << path));
    step();
    check("R5 single cycle", path_rst, 0);
  endtask

  task automatic t_hold();
    hdr_pulse(4'd2);
    rate_code = 4'd7; hdr_done = 1; step(); hdr_done = 0;
    rate_code = 4'd12; step();
    in_valid = 1; out_ready = 5'b11111; #1;
    check("R4 route held", out_valid, 5'b00100);
    in_valid = 0;
    end_pulse();
    check("R4 strobe uses captured path", path_rst, 5'b00101);
    step();
  endtask

  task automatic t_end_hdr();
    end_pulse();
    check("R6 strobe in header", path_rst, 5'b00001);
    in_valid = 1; #1;
    check("R6 stays header", out_valid, 5'b00001);
    in_valid = 0; step();
  endtask

  task automatic t_bad(input logic [3:0] code);
    check("R7 err before capture", rate_err, 0);
    hdr_pulse(code);
    check("R7 err set", rate_err, 1);
    in_valid = 1; out_ready = 5'b11111; #1;
    check("R7 no valid", out_valid, 0);
    check("R7 not ready", in_ready, 0);
    step(); #1;
    check("R7 sticky", rate_err, 1);
    end_pulse(); #1;
    check("R8 err cleared", rate_err, 0);
    check("R8 strobe path0 only", path_rst, 5'b00001);
    check("R8 back to header", out_valid, 5'b00001);
    in_valid = 0; step();
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_header();
        for (int c = 0; c < 8; c++) t_rate(4'(c), c / 2 + 1);
        t_hold();
        t_end_hdr();
        t_bad(4'd8);
        t_bad(4'd15);
        t_rate(4'd6, 4);
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule